// File: doc/BRIEF.md
# Inter-Core Interrupt Router

This block delivers interrupts within a small cluster of cores. A core raises a software trap by presenting a trap value together with its own core index. The low field of the trap value names the destination core, and the remaining upper bits carry the interrupt type. Destination code 0 is an alias for the core that raised the trap. Codes 1 to NUM_CORES name physical cores, where code c selects core index c-1. Any higher code names a core that does not exist. Such a request is discarded, and a sticky error bit is set for the core that raised it.

External hardware interrupt lines are edge-captured and always sent to one fixed home core. Each core has a single pending slot. The slot holds a flag and a type, and the core clears it with its acknowledge input. A trap aimed at a full slot is stalled with a busy signal until the slot drains. When an external interrupt is delivered to the home core in the same cycle that a trap targets that core, the external interrupt takes the slot. The trap then stays stalled and is taken on a later cycle.

Top module: `irq_router`

## Requirements
- R1: After reset, every pending flag, every error flag and `trap_busy` are 0.
- R2: A trap with destination code `trap_value[ID_W-1:0]` = c, where 1 <= c <= NUM_CORES, sets `irq_pend[c-1]` one clock after it is accepted. That core's type then equals `trap_value[TRAP_W-1:ID_W]`.
- R3: Destination code 0 delivers the trap to core index `trap_src`.
- R4: A destination code above NUM_CORES changes no pending slot and does not raise busy. It sets `err_flag[trap_src]` one clock later, and that flag stays set until `err_clr` for that core is asserted.
- R5: While the target slot is full, `trap_busy` is 1 and the slot's type is unchanged. The trap is accepted in the first cycle in which the slot is empty.
- R6: `irq_ack[k]` on a full slot clears `irq_pend[k]` one clock later. On an empty slot it has no effect.
- R7: A rising edge on `ext_irq[j]` delivers type j to core HOME_CORE two clocks after the edge is sampled, provided the home slot is empty. A line held high does not deliver again.
- R8: When several captured external lines wait at the same time, the lowest line index is delivered first. The others follow after acknowledges.
- R9: If an external delivery to the home core and a trap aimed at the home core fall in the same cycle, the external interrupt fills the slot and `trap_busy` is 1. The trap is accepted later.
- R10: When a new error and `err_clr` arrive for the same core in the same cycle, the error flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_valid | input | 1 | Software trap request |
| trap_src | input | SRC_W | Index of the issuing core |
| trap_value | input | TRAP_W | Destination code (low ID_W bits) and type (upper bits) |
| trap_busy | output | 1 | Trap stalled; hold the request |
| ext_irq | input | EXT_N | External interrupt lines, edge-captured |
| irq_ack | input | NUM_CORES | Per-core acknowledge that clears the pending slot |
| irq_pend | output | NUM_CORES | Per-core pending flag |
| irq_type | output | NUM_CORES*TYPE_W | Per-core pending type; core k at bits [k*TYPE_W +: TYPE_W] |
| err_clr | input | NUM_CORES | Per-core error-flag clear |
| err_flag | output | NUM_CORES | Sticky bad-destination flag for each issuing core |

## Verification
`trap_busy` is combinational, so the bench samples it in the same cycle as the request, after the inputs have settled. Trap deliveries, errors and acknowledges take effect one clock after the edge that samples them. External lines pass through two registers, capture and then slot, so their results are checked after the second edge. All inputs are driven and all outputs sampled on the falling edge. The arbitration test counts edges from the external rise to line up the collision on the exact grant cycle.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  typedef enum logic [1:0] {
    TGT_SELF   = 2'd0,
    TGT_NAMED  = 2'd1,
    TGT_ABSENT = 2'd2
  } tgt_kind_e;
endpackage

// File: rtl/irq_target_decode.sv
module irq_target_decode
  import irq_route_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ID_W      = 4,
  parameter int SRC_W     = 2
) (
  input  logic [ID_W-1:0]  dest_code,
  input  logic [SRC_W-1:0] src_idx,
  output tgt_kind_e        kind,
  output logic [SRC_W-1:0] tgt_idx
);
  always_comb begin
    if (dest_code == '0) begin
      kind    = TGT_SELF;
      tgt_idx = src_idx;
    end else if (dest_code <= ID_W'(NUM_CORES)) begin
      kind    = TGT_NAMED;
      tgt_idx = SRC_W'(dest_code - ID_W'(1));
    end else begin
      kind    = TGT_ABSENT;
      tgt_idx = src_idx;
    end
  end
endmodule

// File: rtl/irq_ext_capture.sv
module irq_ext_capture #(
  parameter int EXT_N  = 4,
  parameter int TYPE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EXT_N-1:0]  ext_irq,
  input  logic              take,
  output logic              has_req,
  output logic [TYPE_W-1:0] req_type
);
  logic [EXT_N-1:0] prev_q, pend_q, pend_d, sel_mask;

  always_comb begin
    sel_mask = '0;
    req_type = '0;
    for (int i = EXT_N - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        sel_mask = '0;
        sel_mask[i] = 1'b1;
        req_type = TYPE_W'(i);
      end
    end
    has_req = |pend_q;
    pend_d  = (pend_q & ~(take ? sel_mask : '0)) | (ext_irq & ~prev_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= ext_irq;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/irq_slot.sv
module irq_slot #(
  parameter int TYPE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [TYPE_W-1:0] load_type,
  input  logic              ack,
  output logic              valid,
  output logic [TYPE_W-1:0] slot_type
);
  logic valid_d;

  always_comb begin
    valid_d = valid;
    if (ack)  valid_d = 1'b0;
    if (load) valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid     <= 1'b0;
      slot_type <= '0;
    end else begin
      valid <= valid_d;
      if (load) slot_type <= load_type;
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_route_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ID_W      = 4,
  parameter int TRAP_W    = 12,
  parameter int EXT_N     = 4,
  parameter int HOME_CORE = 0,
  localparam int SRC_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int TYPE_W   = TRAP_W - ID_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        trap_valid,
  input  logic [SRC_W-1:0]            trap_src,
  input  logic [TRAP_W-1:0]           trap_value,
  output logic                        trap_busy,
  input  logic [EXT_N-1:0]            ext_irq,
  input  logic [NUM_CORES-1:0]        irq_ack,
  output logic [NUM_CORES-1:0]        irq_pend,
  output logic [NUM_CORES*TYPE_W-1:0] irq_type,
  input  logic [NUM_CORES-1:0]        err_clr,
  output logic [NUM_CORES-1:0]        err_flag
);
  tgt_kind_e            kind;
  logic [SRC_W-1:0]     tgt_idx;
  logic                 ext_has, ext_take, home_clash, trap_ok, trap_accept, trap_bad;
  logic [TYPE_W-1:0]    ext_type, trap_type;
  logic [NUM_CORES-1:0] err_d;

  assign trap_type = trap_value[TRAP_W-1:ID_W];

  irq_target_decode #(.NUM_CORES(NUM_CORES), .ID_W(ID_W), .SRC_W(SRC_W)) u_dec (
    .dest_code (trap_value[ID_W-1:0]),
    .src_idx   (trap_src),
    .kind      (kind),
    .tgt_idx   (tgt_idx)
  );

  irq_ext_capture #(.EXT_N(EXT_N), .TYPE_W(TYPE_W)) u_ext (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_irq  (ext_irq),
    .take     (ext_take),
    .has_req  (ext_has),
    .req_type (ext_type)
  );

  always_comb begin
    ext_take    = ext_has && !irq_pend[HOME_CORE];
    home_clash  = ext_take && (tgt_idx == SRC_W'(HOME_CORE));
    trap_ok     = trap_valid && (kind != TGT_ABSENT);
    trap_busy   = trap_ok && (irq_pend[tgt_idx] || home_clash);
    trap_accept = trap_ok && !trap_busy;
    trap_bad    = trap_valid && (kind == TGT_ABSENT);
  end

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_core
    logic              ld;
    logic [TYPE_W-1:0] ld_type;
    if (k == HOME_CORE) begin : g_home
      assign ld      = ext_take || (trap_accept && tgt_idx == SRC_W'(k));
      assign ld_type = ext_take ? ext_type : trap_type;
    end else begin : g_other
      assign ld      = trap_accept && tgt_idx == SRC_W'(k);
      assign ld_type = trap_type;
    end
    irq_slot #(.TYPE_W(TYPE_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (ld),
      .load_type (ld_type),
      .ack       (irq_ack[k]),
      .valid     (irq_pend[k]),
      .slot_type (irq_type[k*TYPE_W +: TYPE_W])
    );
    assign err_d[k] = (err_flag[k] && !err_clr[k]) || (trap_bad && trap_src == SRC_W'(k));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_flag <= '0;
    else        err_flag <= err_d;
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_CORES = 4,
  parameter int TYPE_W    = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        trap_valid,
  input logic                        trap_busy,
  input logic [NUM_CORES-1:0]        irq_ack,
  input logic [NUM_CORES-1:0]        irq_pend,
  input logic [NUM_CORES*TYPE_W-1:0] irq_type,
  input logic [NUM_CORES-1:0]        err_clr,
  input logic [NUM_CORES-1:0]        err_flag
);
  p_busy_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_busy |-> trap_valid);

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_chk
    p_pend_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pend[k] && !irq_ack[k]) |=> irq_pend[k]);
    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pend[k] && irq_ack[k]) |=> !irq_pend[k]);
    p_type_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pend[k] && !irq_ack[k]) |=> $stable(irq_type[k*TYPE_W +: TYPE_W]));
    p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flag[k] && !err_clr[k]) |=> err_flag[k]);
  end
endmodule

bind irq_router irq_router_chk #(.NUM_CORES(NUM_CORES), .TYPE_W(TRAP_W - ID_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .trap_valid (trap_valid),
  .trap_busy  (trap_busy),
  .irq_ack    (irq_ack),
  .irq_pend   (irq_pend),
  .irq_type   (irq_type),
  .err_clr    (err_clr),
  .err_flag   (err_flag)
);

// File: tb/sim_irq_router.sv
`timescale 1ns/1ps
module sim_irq_router;
  localparam int NC = 4, IDW = 4, TW = 12, EN = 4, TYW = 8, SW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic trap_valid = 1'b0, trap_busy;
  logic [SW-1:0] trap_src = '0;
  logic [TW-1:0] trap_value = '0;
  logic [EN-1:0] ext_irq = '0;
  logic [NC-1:0] irq_ack = '0, irq_pend, err_clr = '0, err_flag;
  logic [NC*TYW-1:0] irq_type;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_router u0 (.clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_src(trap_src),
    .trap_value(trap_value), .trap_busy(trap_busy), .ext_irq(ext_irq), .irq_ack(irq_ack),
    .irq_pend(irq_pend), .irq_type(irq_type), .err_clr(err_clr), .err_flag(err_flag));

  // vector: {src[1:0], value[11:0], bad, idx[1:0]}
  localparam int NV = 7;
  localparam logic [16:0] VEC [NV] = '{
    {2'd0, 8'h11, 4'd1,  1'b0, 2'd0},
    {2'd1, 8'h22, 4'd3,  1'b0, 2'd2},
    {2'd2, 8'h33, 4'd0,  1'b0, 2'd2},
    {2'd3, 8'h44, 4'd0,  1'b0, 2'd3},
    {2'd1, 8'h55, 4'd4,  1'b0, 2'd3},
    {2'd2, 8'h66, 4'd5,  1'b1, 2'd2},
    {2'd0, 8'h77, 4'd15, 1'b1, 2'd0}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [TYW-1:0] ty(input int k);
    return irq_type[k*TYW +: TYW];
  endfunction

  task automatic drain();
    @(negedge clk); irq_ack = '1; err_clr = '1;
    @(negedge clk); irq_ack = '0; err_clr = '0;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "pend", 32'(irq_pend), 0);
    chk("R1", "err", 32'(err_flag), 0);
    chk("R1", "busy", 32'(trap_busy), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table: R2 named, R3 self, R4 absent
    for (int v = 0; v < NV; v++) begin
      logic [NC-1:0] ep, ee;
      trap_src = VEC[v][16:15]; trap_value = VEC[v][14:3];
      trap_valid = 1'b1;
      #0.5 chk("R2/R3/R4", "busy", 32'(trap_busy), 0);
      @(negedge clk); trap_valid = 1'b0;
      ep = VEC[v][2] ? '0 : NC'(1) << VEC[v][1:0];
      ee = VEC[v][2] ? NC'(1) << VEC[v][16:15] : '0;
      chk("R2/R3/R4", "pend", 32'(irq_pend), 32'(ep));
      chk("R4", "err", 32'(err_flag), 32'(ee));
      if (!VEC[v][2]) chk("R2", "type", 32'(ty(VEC[v][1:0])), 32'(VEC[v][14:7]));
      if (VEC[v][2]) begin
        @(negedge clk);
        chk("R4", "err sticky", 32'(err_flag), 32'(ee));
      end
      drain();
      chk("R6/R4", "cleared", 32'({irq_pend, err_flag}), 0);
    end

    // R5 busy on full slot
    trap_src = 0; trap_value = {8'hA1, 4'd2}; trap_valid = 1'b1;
    @(negedge clk);
    trap_value = {8'hB2, 4'd2};
    #0.5 chk("R5", "busy full", 32'(trap_busy), 1);
    @(negedge clk);
    chk("R5", "type kept", 32'(ty(1)), 32'h A1);
    irq_ack[1] = 1'b1;
    #0.5 chk("R5", "busy during ack", 32'(trap_busy), 1);
    @(negedge clk); irq_ack[1] = 1'b0;
    #0.5 chk("R5", "busy after ack", 32'(trap_busy), 0);
    @(negedge clk); trap_valid = 1'b0;
    chk("R5", "retry accepted", 32'(ty(1)), 32'h B2);
    drain();

    // R6 ack on empty slot
    irq_ack[2] = 1'b1;
    @(negedge clk); irq_ack[2] = 1'b0;
    chk("R6", "empty ack", 32'(irq_pend), 0);

    // R7 external edge to home core
    ext_irq[2] = 1'b1;
    @(negedge clk);
    chk("R7", "after capture", 32'(irq_pend), 0);
    @(negedge clk);
    chk("R7", "delivered", 32'(irq_pend), 1);
    chk("R7", "type", 32'(ty(0)), 2);
    drain();
    repeat (3) @(negedge clk);
    chk("R7", "level no redeliver", 32'(irq_pend), 0);
    ext_irq = '0;
    @(negedge clk);

    // R8 lowest line first
    ext_irq = 4'b1010;
    repeat (2) @(negedge clk);
    chk("R8", "first type", 32'(ty(0)), 1);
    irq_ack[0] = 1'b1;
    @(negedge clk); irq_ack[0] = 1'b0;
    @(negedge clk);
    chk("R8", "second pend", 32'(irq_pend), 1);
    chk("R8", "second type", 32'(ty(0)), 3);
    drain();
    ext_irq = '0;
    @(negedge clk);

    // R9 collision at home core
    ext_irq[0] = 1'b1;
    @(negedge clk);
    trap_src = 2; trap_value = {8'h5C, 4'd1}; trap_valid = 1'b1;
    #0.5 chk("R9", "busy on clash", 32'(trap_busy), 1);
    @(negedge clk);
    chk("R9", "ext wins", 32'(ty(0)), 0);
    chk("R9", "pend", 32'(irq_pend), 1);
    irq_ack[0] = 1'b1;
    @(negedge clk); irq_ack[0] = 1'b0;
    @(negedge clk); trap_valid = 1'b0;
    chk("R9", "trap later", 32'(ty(0)), 32'h5C);
    drain();
    ext_irq = '0;

    // R10 set beats clear
    trap_src = 3; trap_value = {8'h00, 4'd9}; trap_valid = 1'b1; err_clr[3] = 1'b1;
    @(negedge clk); trap_valid = 1'b0; err_clr[3] = 1'b0;
    chk("R10", "set wins", 32'(err_flag), 32'h8);
    chk("R4", "no pend", 32'(irq_pend), 0);
    drain();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule